// File: doc/BRIEF.md
# Wear-Aware Nonvolatile Byte Write Controller

This block sits between a processor's register bus and a small byte-wide nonvolatile data array that the processor cannot address as memory. Software loads a byte address into an address register, places a value in a data register and issues a command through a control register. A read command copies the addressed byte into the data register. A write command does not go straight to the array: the controller first reads the stored byte and compares it with the requested value. It then runs only the array work that the change needs.

The array has two separate operations. An erase drives every bit of one byte to one. A program can only pull selected bits to zero. A write that changes nothing costs no array cycles. A write of all ones needs only an erase. A write that only clears bits that are still one needs only a program. Any other change needs an erase followed by a program. Each phase lasts a fixed, parameterised number of clock cycles. The storage is modelled as a register array, and a phase takes effect on the array when it ends. While the controller is working it holds a busy flag and refuses all register traffic. A single-cycle done pulse marks the end of every write.

Top module: `nvm_wear_ctrl`

## Requirements
- R1: After reset, busy and done are low, phase reads 0, the address and data registers read 0, and every array byte holds all ones.
- R2: A control write with bit0 set and bit1 clear, accepted while idle, loads the data register with the byte at the current address on the next clock edge. It does not raise busy.
- R3: A write command whose data equals the stored byte performs no erase and no program. Busy is high for exactly one cycle (the compare cycle, phase 1).
- R4: A write of all ones to a byte that differs runs only an erase phase (phase 2) of ERASE_CYC cycles. The byte then reads all ones.
- R5: A write whose value only clears bits that are currently one ((old AND new) == new, new != old) runs only a program phase (phase 3) of PROG_CYC cycles. The byte then reads the new value.
- R6: Every other write runs an erase phase of ERASE_CYC cycles and then a program phase of PROG_CYC cycles. The byte then reads the new value.
- R7: Busy rises on the edge that accepts a write and stays high through compare and all phases. Done is high for exactly the one cycle after busy falls.
- R8: While busy, register writes of any kind (address, data or control) are ignored. The address and data registers keep their values, and no second operation starts.
- R9: Register select: 0 = address register (low AW bits of the write data), 1 = data register, 2 = control register (bit0 read, bit1 write; when both are set the write is taken), 3 = no effect.
- R10: The phase output encodes 0 idle, 1 compare, 2 erase, 3 program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | DW | Register write data |
| addr_out | output | AW | Address register contents |
| data_out | output | DW | Data register contents |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| phase | output | 2 | Current activity code |

## Verification
The bench builds the controller with ERASE_CYC=5, PROG_CYC=3 and AW=3. Because the two phase lengths are distinct and small, the measured busy length alone shows whether a write took the skip, erase-only, program-only or combined path. The eight-byte array lets the bench read back every location against its own model after a sequence of writes. A long combined write gives enough busy cycles to land address, data, read and write traffic inside it and confirm that none of it has any effect.

// File: rtl/nvm_wear_pkg.sv
package nvm_wear_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CMP   = 2'd1,
        PH_ERASE = 2'd2,
        PH_PROG  = 2'd3
    } phase_e;

    typedef struct packed {
        logic skip;
        logic erase;
        logic prog;
    } wear_plan_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          erase_en,
    input  logic          prog_en,
    input  logic [DW-1:0] prog_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [DW-1:0] cell_d;
        logic          hit;
        assign hit = (addr == AW'(i));
        always_comb begin
            cell_d = cell_q[i];
            if (hit && erase_en) cell_d = '1;
            else if (hit && prog_en) cell_d = cell_q[i] & prog_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q[i] <= '1;
            else        cell_q[i] <= cell_d;
        end
    end

    assign rd_data = cell_q[addr];
endmodule

// File: rtl/nvm_wear_plan.sv
module nvm_wear_plan
    import nvm_wear_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] new_val,
    output wear_plan_t    plan
);
    logic same;
    logic all_ones;
    logic clear_only;

    always_comb begin
        same       = (old_val == new_val);
        all_ones   = (new_val == {DW{1'b1}});
        clear_only = ((old_val & new_val) == new_val);
        plan.skip  = same;
        plan.erase = !same && (all_ones || !clear_only);
        plan.prog  = !same && !all_ones;
    end
endmodule

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvm_wear_ctrl.sv
module nvm_wear_ctrl
    import nvm_wear_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int ERASE_CYC = 16,
    parameter int PROG_CYC  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] data_out,
    output logic          busy,
    output logic          done,
    output logic [1:0]    phase
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          need_prog;
        logic          done;
    } ctrl_t;

    ctrl_t         st_d, st_q;
    wear_plan_t    plan;
    logic [DW-1:0] arr_rd;
    logic          arr_erase, arr_prog;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          accept;

    nvm_cell_array #(.AW(AW), .DW(DW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (st_q.addr),
        .erase_en  (arr_erase),
        .prog_en   (arr_prog),
        .prog_data (st_q.data),
        .rd_data   (arr_rd)
    );

    nvm_wear_plan #(.DW(DW)) u_plan (
        .old_val (arr_rd),
        .new_val (st_q.data),
        .plan    (plan)
    );

    nvm_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        arr_erase = 1'b0;
        arr_prog  = 1'b0;
        accept    = reg_wr && (st_q.ph == PH_IDLE);

        unique case (st_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    case (reg_sel)
                        SEL_ADDR: st_d.addr = reg_wdata[AW-1:0];
                        SEL_DATA: st_d.data = reg_wdata;
                        SEL_CTRL: begin
                            if (reg_wdata[1])      st_d.ph   = PH_CMP;
                            else if (reg_wdata[0]) st_d.data = arr_rd;
                        end
                        default: ;
                    endcase
                end
            end
            PH_CMP: begin
                if (plan.skip) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end else if (plan.erase) begin
                    st_d.ph        = PH_ERASE;
                    st_d.need_prog = plan.prog;
                    tmr_load       = 1'b1;
                    tmr_val        = TW'(ERASE_CYC - 1);
                end else begin
                    st_d.ph        = PH_PROG;
                    st_d.need_prog = 1'b0;
                    tmr_load       = 1'b1;
                    tmr_val        = TW'(PROG_CYC - 1);
                end
            end
            PH_ERASE: begin
                if (tmr_expired) begin
                    arr_erase = 1'b1;
                    if (st_q.need_prog) begin
                        st_d.ph   = PH_PROG;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(PROG_CYC - 1);
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = 1'b1;
                    end
                end
            end
            PH_PROG: begin
                if (tmr_expired) begin
                    arr_prog       = 1'b1;
                    st_d.ph        = PH_IDLE;
                    st_d.need_prog = 1'b0;
                    st_d.done      = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph        <= PH_IDLE;
            st_q.addr      <= '0;
            st_q.data      <= '0;
            st_q.need_prog <= 1'b0;
            st_q.done      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out = st_q.addr;
    assign data_out = st_q.data;
    assign busy     = (st_q.ph != PH_IDLE);
    assign done     = st_q.done;
    assign phase    = st_q.ph;
endmodule

// File: rtl/nvm_wear_ctrl_chk.sv
module nvm_wear_ctrl_chk #(
    parameter int AW        = 4,
    parameter int ERASE_CYC = 16,
    parameter int PROG_CYC  = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] addr_out,
    input logic          busy,
    input logic          done,
    input logic [1:0]    phase
);
    int unsigned erase_run_q, prog_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_run_q <= 0;
            prog_run_q  <= 0;
        end else begin
            erase_run_q <= (phase == 2'd2) ? erase_run_q + 1 : 0;
            prog_run_q  <= (phase == 2'd3) ? prog_run_q + 1 : 0;
        end
    end

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    addr_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> $stable(addr_out));

    // R3
    cmp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |=> (phase != 2'd1));

    // R4
    erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd2 && erase_run_q != 0) |-> (erase_run_q == ERASE_CYC));

    // R5
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd3 && prog_run_q != 0) |-> (prog_run_q == PROG_CYC));

    // R6
    erase_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |=> (phase == 2'd2 || phase == 2'd3 || phase == 2'd0));
endmodule

bind nvm_wear_ctrl nvm_wear_ctrl_chk #(
    .AW(AW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .addr_out(addr_out),
    .busy(busy), .done(done), .phase(phase)
);

// File: tb/sim_nvm_wear_ctrl.sv
module sim_nvm_wear_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int EC = 5;
    localparam int PC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [AW-1:0] addr_out;
    logic [DW-1:0] data_out;
    logic          busy, done;
    logic [1:0]    phase;

    int errors = 0;
    int checks = 0;

    typedef struct {
        int    busy_n;
        int    cmp_n;
        int    ers_n;
        int    prg_n;
        string req;
    } exp_t;

    exp_t exp_q[$];
    logic [DW-1:0] model [1 << AW];
    int c_busy = 0, c_cmp = 0, c_ers = 0, c_prg = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvm_wear_ctrl #(.AW(AW), .DW(DW), .ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_out(addr_out), .data_out(data_out),
        .busy(busy), .done(done), .phase(phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) c_busy++;
            if (phase == 2'd1) c_cmp++;
            if (phase == 2'd2) c_ers++;
            if (phase == 2'd3) c_prg++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(c_busy == e.busy_n, {e.req, " R7 busy length"}, c_busy, e.busy_n);
                    check(c_cmp == e.cmp_n, {e.req, " R10 compare cycles"}, c_cmp, e.cmp_n);
                    check(c_ers == e.ers_n, {e.req, " erase cycles"}, c_ers, e.ers_n);
                    check(c_prg == e.prg_n, {e.req, " program cycles"}, c_prg, e.prg_n);
                end
                c_busy = 0; c_cmp = 0; c_ers = 0; c_prg = 0;
            end
        end
    end

    task automatic reg_put(input logic [1:0] sel, input logic [DW-1:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string req);
        reg_put(2'd0, DW'(a));
        reg_put(2'd2, 8'h01);
        check(data_out == model[a], req, data_out, model[a]);
        check(busy == 1'b0, {req, " read keeps busy low"}, busy, 0);
    endtask

    task automatic push_exp(input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
        exp_t e;
        logic [DW-1:0] old;
        bit er, pr;
        old = model[a];
        er = 0; pr = 0;
        if (old != v) begin
            if (v == 8'hFF) er = 1;
            else if ((old & v) == v) pr = 1;
            else begin er = 1; pr = 1; end
        end
        e.ers_n = er ? EC : 0;
        e.prg_n = pr ? PC : 0;
        e.cmp_n = 1;
        e.busy_n = 1 + e.ers_n + e.prg_n;
        e.req = req;
        exp_q.push_back(e);
        model[a] = v;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v,
                            input logic [DW-1:0] ctl, input string req);
        push_exp(a, v, req);
        reg_put(2'd0, DW'(a));
        reg_put(2'd1, v);
        reg_put(2'd2, ctl);
        wait_done();
        check(done == 1'b1, {req, " R7 done seen"}, done, 1);
        @(negedge clk);
        check(done == 1'b0, {req, " R7 done one cycle"}, done, 0);
        read_chk(a, {req, " read back"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        check(phase == 2'd0, "R1 phase", phase, 0);
        check(addr_out == 0 && data_out == 0, "R1 regs", data_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < (1 << AW); i++) read_chk(AW'(i), "R1 R2 erased array read");

        do_write(3'd2, 8'hA5, 8'h02, "R5 program only");
        do_write(3'd2, 8'hA5, 8'h02, "R3 skip equal");
        do_write(3'd2, 8'h21, 8'h02, "R5 clear more bits");
        do_write(3'd2, 8'h5A, 8'h02, "R6 erase+program");
        do_write(3'd2, 8'hFF, 8'h02, "R4 erase only");
        do_write(3'd5, 8'h00, 8'h02, "R5 all zero");
        do_write(3'd5, 8'h0F, 8'h03, "R9 both bits write wins R6");
        do_write(3'd6, 8'h0F, 8'h02, "R5 setup");

        // R8 traffic while busy is ignored
        push_exp(3'd6, 8'hF0, "R8 busy write");
        reg_put(2'd1, 8'hF0);
        reg_put(2'd2, 8'h02);
        reg_put(2'd0, 8'h01);
        reg_put(2'd1, 8'h77);
        reg_put(2'd2, 8'h01);
        reg_put(2'd2, 8'h02);
        wait_done();
        @(negedge clk);
        check(addr_out == 3'd6, "R8 address held", addr_out, 6);
        check(data_out == 8'hF0, "R8 data held", data_out, 8'hF0);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && !busy, "R8 no second operation", exp_q.size(), 0);
        read_chk(3'd1, "R8 addr1 untouched");
        read_chk(3'd6, "R8 addr6 value");

        // R9 select 3 has no effect
        reg_put(2'd3, 8'h05);
        check(addr_out == 3'd6 && data_out == 8'hF0, "R9 select 3 ignored", data_out, 8'hF0);
        check(!busy, "R9 select 3 no op", busy, 0);

        for (int i = 0; i < (1 << AW); i++) read_chk(AW'(i), "R2 final scan");
        summary();
        $finish;
    end
endmodule